// File: doc/BRIEF.md
# SDRAM Device Command Front End

This block is the command-facing front of a four-bank synchronous DRAM model. On every rising clock edge it captures the chip-select, the three command strobes, the bank bits, the address bus and the two byte-mask pins. It then turns the captured pattern into a command kind, along with the fields that command carries. The block also keeps three kinds of state. The first is a per-bank record of whether a row is open, and which row. The second is the mode register, split into its burst, latency and write-mode fields. The third is a sticky flag raised by any command that the current bank state does not allow.

A datapath or burst sequencer sits behind this block and uses the command strobe in the cycle after the sampling edge: the bank and column, the auto-precharge and precharge-all qualifiers, and the per-byte write mask. The byte-mask pins also drive a separate delay line. That line gives the read output-disable two clocks after the mask is sampled, while the write mask takes effect with no added delay. An illegal command changes no state. It only sets the error flag, which stays set until reset.

Top module: `sdcmd_front`

## Requirements
- R1: All pins are sampled on the rising clock edge. The command captured at edge k appears on `cmd_kind` between edge k and edge k+1. With chip select low, {ras_n,cas_n,we_n} maps as follows: 111 to 0 (no operation), 011 to 1 (activate), 101 to 2 (read), 100 to 3 (write), 110 to 4 (burst stop), 010 to 5 (precharge), 001 to 6 (auto refresh), 000 to 7 (mode load).
- R2: When cs_n is sampled high, `cmd_kind` is 0 whatever the other pins are, and no bank, mode or error state changes.
- R3: A legal activate opens bank `ba` and stores addr[12:0] as its row. Both are visible on `bank_open` and `bank_row` (bank i at bits i*13+12..i*13) from the next edge on. An activate to a bank that is already open is illegal.
- R4: A precharge with addr[10] low closes only bank `ba`. With addr[10] high it closes all banks and raises `pre_all`. Precharge is always legal.
- R5: For read or write, `col_addr` carries addr[8:0] and `bank_sel` carries `ba`, and `auto_pre` carries addr[10]. With `auto_pre` high the bank is recorded idle at the next edge. A read or write to an idle bank is illegal. For commands other than activate, read, write and precharge, `bank_sel` is 0, and `col_addr` and `auto_pre` are 0 outside read and write.
- R6: A legal mode load sets the fields from the address: burst length from addr[2:0], interleaved type from addr[3], CAS latency from addr[6:4], operating mode from addr[8:7], and single-write burst from addr[9]. Bits 12:10 are ignored. The fields keep their value until the next legal load.
- R7: A mode load or auto refresh while any bank is open is illegal. Every illegal command sets `err_flag` from the next edge on and changes no other state. Only reset clears the flag.
- R8: `wr_mask[0]` (low byte) and `wr_mask[1]` (high byte) equal dqm as sampled at the same edge as the command, and are valid alongside `cmd_kind`.
- R9: `rd_hiz[i]` is high from edge k+2 to edge k+3 when dqm[i] is sampled high at edge k.
- R10: After reset all banks are idle, all mode fields are 0, `err_flag` is 0, the command output is 0 and the mask outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column and mode opcode bus |
| dqm | input | 2 | Byte masks, bit 0 low byte |
| cmd_kind | output | 3 | Decoded command (R1 encoding) |
| bank_sel | output | 2 | Bank of the current command |
| col_addr | output | 9 | Start column for read or write |
| auto_pre | output | 1 | Read or write with auto-precharge |
| pre_all | output | 1 | Precharge of every bank |
| wr_mask | output | 2 | Per-byte write data mask |
| rd_hiz | output | 2 | Per-byte read output disable |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| bank_row | output | 52 | Stored row of each bank |
| mode_blen | output | 3 | Burst length code |
| mode_ilv | output | 1 | Interleaved burst order |
| mode_cl | output | 3 | CAS latency code |
| mode_op | output | 2 | Operating mode code |
| mode_wsingle | output | 1 | Single-location write bursts |
| err_flag | output | 1 | Sticky illegal-command flag |

## Verification
The command, bank, column, qualifier and write-mask outputs are due one edge after the pins are sampled. Bank, row, mode and error state are due one edge later, and the read output-disable is due two edges after sampling. The bench model captures the pins at each rising edge, updates its own state one edge after capture and keeps a short queue of sampled masks so that it reads the entry from two edges earlier. All outputs are compared at the falling edge, when each of these delays has completed.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

   typedef enum logic [2:0] {
      CK_NONE  = 3'd0,
      CK_ACT   = 3'd1,
      CK_READ  = 3'd2,
      CK_WRITE = 3'd3,
      CK_STOP  = 3'd4,
      CK_PRE   = 3'd5,
      CK_REFR  = 3'd6,
      CK_LOAD  = 3'd7
   } cmd_kind_e;

   // Field order follows the opcode bit positions (bit 9 down to bit 0).
   typedef struct packed {
      logic       wsingle;
      logic [1:0] op;
      logic [2:0] cl;
      logic       ilv;
      logic [2:0] blen;
   } mode_t;

   localparam int MODE_BITS = $bits(mode_t);

   function automatic cmd_kind_e pins_to_kind(input logic sel_n, input logic r_n,
                                              input logic c_n, input logic w_n);
      cmd_kind_e k;
      if (sel_n) begin
         k = CK_NONE;
      end else begin
         unique case ({r_n, c_n, w_n})
            3'b011:  k = CK_ACT;
            3'b101:  k = CK_READ;
            3'b100:  k = CK_WRITE;
            3'b110:  k = CK_STOP;
            3'b010:  k = CK_PRE;
            3'b001:  k = CK_REFR;
            3'b000:  k = CK_LOAD;
            default: k = CK_NONE;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/sdcmd_capture.sv
`timescale 1ns/1ps
module sdcmd_capture #(
   parameter int BA_W  = 2,
   parameter int A_W   = 13,
   parameter int DQM_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [BA_W-1:0]  ba,
   input  logic [A_W-1:0]   addr,
   input  logic [DQM_W-1:0] dqm,
   output logic             cs_q,
   output logic             ras_q,
   output logic             cas_q,
   output logic             we_q,
   output logic [BA_W-1:0]  ba_q,
   output logic [A_W-1:0]   addr_q,
   output logic [DQM_W-1:0] dqm_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         ras_q  <= 1'b1;
         cas_q  <= 1'b1;
         we_q   <= 1'b1;
         ba_q   <= '0;
         addr_q <= '0;
         dqm_q  <= '0;
      end else begin
         cs_q   <= cs_n;
         ras_q  <= ras_n;
         cas_q  <= cas_n;
         we_q   <= we_n;
         ba_q   <= ba;
         addr_q <= addr;
         dqm_q  <= dqm;
      end
   end

endmodule

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
module sdcmd_decode
   import sdcmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2,
   parameter int COL_W     = 9
) (
   input  logic                 cs_q,
   input  logic                 ras_q,
   input  logic                 cas_q,
   input  logic                 we_q,
   input  logic [BA_W-1:0]      ba_q,
   input  logic [COL_W-1:0]     col_q,
   input  logic                 ap_q,
   input  logic [NUM_BANKS-1:0] open_now,
   output cmd_kind_e            kind,
   output logic                 legal,
   output logic [BA_W-1:0]      bank_sel,
   output logic [COL_W-1:0]     col_addr,
   output logic                 auto_pre,
   output logic                 pre_all
);

   logic is_col, uses_bank, any_open, tgt_open;

   always_comb begin
      kind      = pins_to_kind(cs_q, ras_q, cas_q, we_q);
      is_col    = (kind == CK_READ) || (kind == CK_WRITE);
      uses_bank = is_col || (kind == CK_ACT) || (kind == CK_PRE);
      any_open  = |open_now;
      tgt_open  = open_now[ba_q];

      bank_sel  = uses_bank ? ba_q : '0;
      col_addr  = is_col ? col_q : '0;
      auto_pre  = is_col && ap_q;
      pre_all   = (kind == CK_PRE) && ap_q;

      unique case (kind)
         CK_ACT:            legal = !tgt_open;
         CK_READ, CK_WRITE: legal = tgt_open;
         CK_REFR, CK_LOAD:  legal = !any_open;
         default:           legal = 1'b1;
      endcase
   end

endmodule

// File: rtl/sdcmd_bank_track.sv
`timescale 1ns/1ps
module sdcmd_bank_track
   import sdcmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2,
   parameter int ROW_W     = 13
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  cmd_kind_e                  kind,
   input  logic                       legal,
   input  logic [BA_W-1:0]            ba_q,
   input  logic [ROW_W-1:0]           row_q,
   input  logic                       ap_q,
   output logic [NUM_BANKS-1:0]       open_now,
   output logic [NUM_BANKS*ROW_W-1:0] rows_flat
);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic             hit;
      logic             opn;
      logic [ROW_W-1:0] row;

      assign hit = legal && (ba_q == BA_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            opn <= 1'b0;
            row <= '0;
         end else begin
            if (hit && kind == CK_ACT) begin
               opn <= 1'b1;
               row <= row_q;
            end else if (kind == CK_PRE && legal && (ap_q || hit)) begin
               opn <= 1'b0;
            end else if (hit && ap_q && (kind == CK_READ || kind == CK_WRITE)) begin
               opn <= 1'b0;
            end
         end
      end

      assign open_now[i]             = opn;
      assign rows_flat[i*ROW_W +: ROW_W] = row;
   end

endmodule

// File: rtl/sdcmd_mode_reg.sv
`timescale 1ns/1ps
module sdcmd_mode_reg
   import sdcmd_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  cmd_kind_e            kind,
   input  logic                 legal,
   input  logic [MODE_BITS-1:0] opcode,
   output mode_t                mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (legal && kind == CK_LOAD) begin
         mode <= mode_t'(opcode);
      end
   end

endmodule

// File: rtl/sdcmd_dqm_pipe.sv
`timescale 1ns/1ps
module sdcmd_dqm_pipe #(
   parameter int DQM_W = 2,
   parameter int LAT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DQM_W-1:0] din,
   output logic [DQM_W-1:0] dout
);

   if (LAT == 0) begin : g_pass
      assign dout = din;
   end else begin : g_shift
      logic [LAT-1:0][DQM_W-1:0] stg;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg <= '0;
         end else begin
            stg[0] <= din;
            for (int k = 1; k < LAT; k++) begin
               stg[k] <= stg[k-1];
            end
         end
      end

      assign dout = stg[LAT-1];
   end

endmodule

// File: rtl/sdcmd_front.sv
`timescale 1ns/1ps
module sdcmd_front
   import sdcmd_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int ROW_W       = 13,
   parameter int COL_W       = 9,
   parameter int AP_BIT      = 10,
   parameter int DQM_W       = 2,
   parameter int RD_MASK_LAT = 2,
   localparam int BA_W       = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BA_W-1:0]            ba,
   input  logic [ROW_W-1:0]           addr,
   input  logic [DQM_W-1:0]           dqm,
   output logic [2:0]                 cmd_kind,
   output logic [BA_W-1:0]            bank_sel,
   output logic [COL_W-1:0]           col_addr,
   output logic                       auto_pre,
   output logic                       pre_all,
   output logic [DQM_W-1:0]           wr_mask,
   output logic [DQM_W-1:0]           rd_hiz,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_row,
   output logic [2:0]                 mode_blen,
   output logic                       mode_ilv,
   output logic [2:0]                 mode_cl,
   output logic [1:0]                 mode_op,
   output logic                       mode_wsingle,
   output logic                       err_flag
);

   // Elaboration-time configuration checks
   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
      $error("sdcmd_front: NUM_BANKS must be a power of two, at least 2");
   end
   if (AP_BIT >= ROW_W || COL_W > AP_BIT) begin : g_bad_ap
      $error("sdcmd_front: AP_BIT must lie above the column field and inside the bus");
   end
   if (ROW_W < MODE_BITS) begin : g_bad_mode
      $error("sdcmd_front: address bus narrower than the mode opcode");
   end
   if (RD_MASK_LAT < 0 || RD_MASK_LAT > 8) begin : g_bad_lat
      $error("sdcmd_front: RD_MASK_LAT out of range");
   end

   logic             cs_q, ras_q, cas_q, we_q;
   logic [BA_W-1:0]  ba_q;
   logic [ROW_W-1:0] addr_q;
   logic [DQM_W-1:0] dqm_q;
   cmd_kind_e        kind;
   logic             legal;
   mode_t            mode;
   logic             err_q;

   sdcmd_capture #(.BA_W(BA_W), .A_W(ROW_W), .DQM_W(DQM_W)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .dqm(dqm),
      .cs_q(cs_q), .ras_q(ras_q), .cas_q(cas_q), .we_q(we_q),
      .ba_q(ba_q), .addr_q(addr_q), .dqm_q(dqm_q)
   );

   sdcmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .COL_W(COL_W)) u_dec (
      .cs_q(cs_q), .ras_q(ras_q), .cas_q(cas_q), .we_q(we_q),
      .ba_q(ba_q), .col_q(addr_q[COL_W-1:0]), .ap_q(addr_q[AP_BIT]),
      .open_now(bank_open),
      .kind(kind), .legal(legal), .bank_sel(bank_sel), .col_addr(col_addr),
      .auto_pre(auto_pre), .pre_all(pre_all)
   );

   sdcmd_bank_track #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .kind(kind), .legal(legal),
      .ba_q(ba_q), .row_q(addr_q), .ap_q(addr_q[AP_BIT]),
      .open_now(bank_open), .rows_flat(bank_row)
   );

   sdcmd_mode_reg u_mode (
      .clk(clk), .rst_n(rst_n), .kind(kind), .legal(legal),
      .opcode(addr_q[MODE_BITS-1:0]), .mode(mode)
   );

   sdcmd_dqm_pipe #(.DQM_W(DQM_W), .LAT(RD_MASK_LAT)) u_rdmask (
      .clk(clk), .rst_n(rst_n), .din(dqm_q), .dout(rd_hiz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (!legal) begin
         err_q <= 1'b1;
      end
   end

   assign cmd_kind     = kind;
   assign wr_mask      = dqm_q;
   assign err_flag     = err_q;
   assign mode_blen    = mode.blen;
   assign mode_ilv     = mode.ilv;
   assign mode_cl      = mode.cl;
   assign mode_op      = mode.op;
   assign mode_wsingle = mode.wsingle;

endmodule

// File: rtl/sdcmd_front_chk.sv
`timescale 1ns/1ps
module sdcmd_front_chk #(
   parameter int NUM_BANKS   = 4,
   parameter int DQM_W       = 2,
   parameter int RD_MASK_LAT = 2,
   localparam int BA_W       = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [DQM_W-1:0]     dqm,
   input logic [2:0]           cmd_kind,
   input logic [BA_W-1:0]      bank_sel,
   input logic                 auto_pre,
   input logic                 pre_all,
   input logic [DQM_W-1:0]     wr_mask,
   input logic [DQM_W-1:0]     rd_hiz,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic [9:0]           mode_bits,
   input logic                 err_flag
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   // R3
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_kind == 3'd1 && !bank_open[bank_sel]) |=> bank_open[$past(bank_sel)]);

   // R4
   pre_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_kind == 3'd5 && pre_all) |=> (bank_open == '0));

   // R5
   auto_pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_kind == 3'd2 || cmd_kind == 3'd3) && auto_pre && bank_open[bank_sel])
      |=> !bank_open[$past(bank_sel)]);

   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_kind != 3'd7) |=> $stable(mode_bits));

   // R8
   wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0) |-> (wr_mask == $past(dqm)));

   if (RD_MASK_LAT == 2) begin : g_rd
      // R9
      rd_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst == 2'd3) |-> (rd_hiz == $past(dqm, 3)));
   end

endmodule

bind sdcmd_front sdcmd_front_chk #(
   .NUM_BANKS(NUM_BANKS), .DQM_W(DQM_W), .RD_MASK_LAT(RD_MASK_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dqm(dqm), .cmd_kind(cmd_kind),
   .bank_sel(bank_sel), .auto_pre(auto_pre), .pre_all(pre_all),
   .wr_mask(wr_mask), .rd_hiz(rd_hiz), .bank_open(bank_open),
   .mode_bits({mode_wsingle, mode_op, mode_cl, mode_ilv, mode_blen}),
   .err_flag(err_flag)
);

// File: tb/sdcmd_front_test.sv
`timescale 1ns/1ps
module sdcmd_front_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [1:0]  dqm = '0;

   logic [2:0]  cmd_kind;
   logic [1:0]  bank_sel;
   logic [8:0]  col_addr;
   logic        auto_pre, pre_all;
   logic [1:0]  wr_mask, rd_hiz;
   logic [3:0]  bank_open;
   logic [51:0] bank_row;
   logic [2:0]  mode_blen, mode_cl;
   logic        mode_ilv, mode_wsingle;
   logic [1:0]  mode_op;
   logic        err_flag;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   sdcmd_front uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .dqm(dqm),
      .cmd_kind(cmd_kind), .bank_sel(bank_sel), .col_addr(col_addr),
      .auto_pre(auto_pre), .pre_all(pre_all), .wr_mask(wr_mask), .rd_hiz(rd_hiz),
      .bank_open(bank_open), .bank_row(bank_row),
      .mode_blen(mode_blen), .mode_ilv(mode_ilv), .mode_cl(mode_cl),
      .mode_op(mode_op), .mode_wsingle(mode_wsingle), .err_flag(err_flag)
   );

   // ---------------- reference model ----------------
   logic        m_cs = 1, m_r = 1, m_c = 1, m_w = 1;
   logic [1:0]  m_ba = 0;
   logic [12:0] m_addr = 0;
   logic [1:0]  m_dqm = 0;
   bit          m_open [4];
   logic [12:0] m_row [4];
   logic [9:0]  m_mode = 0;
   bit          m_err = 0;
   logic [1:0]  hist [$];
   int          edges_up = 0;

   function automatic int kind_of(logic s, logic r, logic c, logic w);
      if (s) return 0;
      case ({r, c, w})
         3'b011: return 1;
         3'b101: return 2;
         3'b100: return 3;
         3'b110: return 4;
         3'b010: return 5;
         3'b001: return 6;
         3'b000: return 7;
         default: return 0;
      endcase
   endfunction

   function automatic bit any_open();
      return m_open[0] | m_open[1] | m_open[2] | m_open[3];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cs = 1; m_r = 1; m_c = 1; m_w = 1; m_ba = 0; m_addr = 0; m_dqm = 0;
         foreach (m_open[i]) begin m_open[i] = 0; m_row[i] = 0; end
         m_mode = 0; m_err = 0;
         hist.delete(); hist.push_back(2'b00); hist.push_back(2'b00);
         edges_up = 0;
      end else begin
         case (kind_of(m_cs, m_r, m_c, m_w))
            1: if (m_open[m_ba]) m_err = 1;
               else begin m_open[m_ba] = 1; m_row[m_ba] = m_addr; end
            2, 3: if (!m_open[m_ba]) m_err = 1;
                  else if (m_addr[10]) m_open[m_ba] = 0;
            5: if (m_addr[10]) foreach (m_open[i]) m_open[i] = 0;
               else m_open[m_ba] = 0;
            6: if (any_open()) m_err = 1;
            7: if (any_open()) m_err = 1;
               else m_mode = m_addr[9:0];
            default: ;
         endcase
         m_cs = cs_n; m_r = ras_n; m_c = cas_n; m_w = we_n;
         m_ba = ba; m_addr = addr; m_dqm = dqm;
         hist.push_back(dqm);
         if (hist.size() > 3) void'(hist.pop_front());
         edges_up++;
      end
   end

   task automatic chk(input string req, input string nm, input logic [63:0] act,
                      input logic [63:0] exp);
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && edges_up >= 1 && !done) begin
         int k;
         logic [51:0] rows;
         logic [3:0]  opn;
         k = kind_of(m_cs, m_r, m_c, m_w);
         for (int i = 0; i < 4; i++) begin
            rows[i*13 +: 13] = m_row[i];
            opn[i] = m_open[i];
         end
         vectors++;
         chk("R1/R2", "cmd_kind", 64'(cmd_kind), 64'(k));
         chk("R5", "bank_sel", 64'(bank_sel), (k == 1 || k == 2 || k == 3 || k == 5) ? 64'(m_ba) : 64'd0);
         chk("R5", "col_addr", 64'(col_addr), (k == 2 || k == 3) ? 64'(m_addr[8:0]) : 64'd0);
         chk("R5", "auto_pre", 64'(auto_pre), 64'((k == 2 || k == 3) && m_addr[10]));
         chk("R4", "pre_all", 64'(pre_all), 64'(k == 5 && m_addr[10]));
         chk("R8", "wr_mask", 64'(wr_mask), 64'(m_dqm));
         chk("R9", "rd_hiz", 64'(rd_hiz), 64'(hist[hist.size()-3]));
         chk("R3/R4", "bank_open", 64'(bank_open), 64'(opn));
         chk("R3", "bank_row", 64'(bank_row), 64'(rows));
         chk("R6", "mode", 64'({mode_wsingle, mode_op, mode_cl, mode_ilv, mode_blen}), 64'(m_mode));
         chk("R7", "err_flag", 64'(err_flag), 64'(m_err));
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic [12:0] a,
                        input logic [1:0] m, input logic s = 1'b0);
      cs_n = s; {ras_n, cas_n, we_n} = c; ba = b; addr = a; dqm = m;
      @(negedge clk);
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) drive(3'b111, 2'd0, 13'd0, 2'b00);
   endtask

   task automatic reset_check();
      // R10: state and outputs at reset values
      vectors++;
      if (err_flag !== 0 || bank_open !== 0 || cmd_kind !== 0 || wr_mask !== 0 || rd_hiz !== 0 ||
          {mode_wsingle, mode_op, mode_cl, mode_ilv, mode_blen} !== 0) begin
         misses++;
         $display("FAIL R10 reset: actual err=%0b open=%0h kind=%0d mode=%0h expected all 0",
                  err_flag, bank_open, cmd_kind,
                  {mode_wsingle, mode_op, mode_cl, mode_ilv, mode_blen});
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      nop(3);
      rst_n = 1;
      nop(1);
      reset_check();
   endtask

   localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                          C_BST = 3'b110, C_PRE = 3'b010, C_REF = 3'b001, C_LMR = 3'b000;

   initial begin
      @(negedge clk);
      do_reset();
      // R6: legal load with all banks idle, reserved high bits set
      drive(C_LMR, 2'd0, {1'b1, 2'b11, 1'b1, 2'b01, 3'b011, 1'b1, 3'b010}, 2'b00);
      nop(2);
      // R3: open bank 2
      drive(C_ACT, 2'd2, 13'h1ABC, 2'b00);
      // R5, R8, R9: read and write with masks
      drive(C_RD, 2'd2, 13'h01F5, 2'b01);
      drive(C_WR, 2'd2, 13'h0003, 2'b10);
      nop(3);
      // R2: masked activate to bank 0
      drive(C_ACT, 2'd0, 13'h0777, 2'b11, 1'b1);
      nop(2);
      // R3/R4: open banks 0 and 3, close 0 alone, then all
      drive(C_ACT, 2'd0, 13'h0123, 2'b00);
      drive(C_ACT, 2'd3, 13'h1FFF, 2'b00);
      drive(C_PRE, 2'd0, 13'h0000, 2'b00);
      nop(1);
      drive(C_PRE, 2'd1, 13'h0400, 2'b00);
      nop(1);
      // R5: read with auto-precharge closes bank 1
      drive(C_ACT, 2'd1, 13'h0042, 2'b00);
      drive(C_RD, 2'd1, 13'h0488, 2'b11);
      nop(2);
      // R1: refresh and burst stop while idle, R6 second load
      drive(C_REF, 2'd0, 13'h0000, 2'b00);
      drive(C_BST, 2'd0, 13'h0000, 2'b00);
      drive(C_LMR, 2'd0, 13'h0231, 2'b00);
      nop(2);
      // R7: illegal mode load with a bank open, then read to idle bank
      drive(C_ACT, 2'd3, 13'h0005, 2'b00);
      drive(C_LMR, 2'd0, 13'h03FF, 2'b00);
      drive(C_RD, 2'd0, 13'h0001, 2'b00);
      drive(C_ACT, 2'd3, 13'h0AAA, 2'b00);
      drive(C_REF, 2'd0, 13'h0000, 2'b00);
      nop(3);
      // R9: isolated mask pulses
      drive(C_NOP, 2'd0, 13'd0, 2'b10);
      nop(1);
      drive(C_NOP, 2'd0, 13'd0, 2'b01);
      nop(4);
      // R10 again, then a legal load after reset
      do_reset();
      drive(C_LMR, 2'd0, 13'h0155, 2'b00);
      nop(2);
      // mixed traffic
      for (int i = 0; i < 600; i++) begin
         logic [2:0] c;
         c = 3'($urandom_range(0, 7));
         drive(c, 2'($urandom), 13'($urandom), 2'($urandom), ($urandom_range(0, 9) == 0));
      end
      nop(4);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         misses++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule